// File: doc/BRIEF.md
# GPIO Port Register Bank

A memory-mapped register bank for a general-purpose I/O port of up to 16 pins. A simple register bus (address, write data, access size, write strobe, read strobe) reaches three main registers: the pin data register and two interrupt-enable masks (channel A and channel B). Each of these three has four addresses: a plain write, and bitwise clear, set and toggle aliases. Clear, set and toggle aliases change only the bits where the written value holds a 1. This lets software change single pins without a read-modify-write sequence.

Five further plain registers configure the pins. They select direction, active polarity, edge versus level sensing, dual-edge sensing and input enable. The bank drives the output pin values and the output enables. It presents every configuration and mask register to a neighbouring interrupt unit. For input pins whose input buffer is enabled, it takes in values that an external sampler has already synchronised. Any access of the wrong width, or at an address outside the map, raises a one-cycle error strobe and leaves every register unchanged.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and all configuration outputs are zero.
- R2: A valid write to a plain address replaces the register: data 0x00, mask A 0x10, mask B 0x20, direction 0x30, polarity 0x34, edge 0x38, dual-edge 0x3C, input enable 0x40. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R3: A write to a clear alias (base+0x04) clears each bit of its base register where the written value is 1; other bits keep their value.
- R4: A write to a set alias (base+0x08) ORs the written value into its base register.
- R5: A write to a toggle alias (base+0x0C) XORs the written value into its base register.
- R6: A read at any clear, set or toggle alias returns the current value of its base register.
- R7: `pin_oe` equals the direction register (1 = output). `pin_out` carries the data bit on output pins and 0 on input pins.
- R8: While `smp_valid` is high, each data bit whose pin has direction 0 and input enable 1 takes the matching `pin_in` bit at the clock edge. All other data bits are unchanged.
- R9: When a write to the data register or to any of its aliases falls in the same cycle as `smp_valid`, the write applies and sampling is ignored for that cycle.
- R10: An access with `bus_size` other than 2'b01 (16-bit; 2'b00 = 8-bit, 2'b10 = 32-bit), with address bits [1:0] non-zero, or with a word offset above 0x40 raises `bus_err` for exactly the next cycle and changes no register.
- R11: A read that is invalid under R10 returns zero on `bus_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_size | input | 2 | Access width code, 2'b01 = 16 bits |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle strobe for an invalid access |
| pin_in | input | 16 | Sampled pin levels |
| smp_valid | input | 1 | Sampled levels are valid this cycle |
| pin_out | output | 16 | Output pin values |
| pin_oe | output | 16 | Output enables |
| cfg_mask_a | output | 16 | Interrupt mask, channel A |
| cfg_mask_b | output | 16 | Interrupt mask, channel B |
| cfg_polar | output | 16 | Polarity configuration |
| cfg_edge | output | 16 | Edge-sense select |
| cfg_both | output | 16 | Dual-edge select |
| cfg_inen | output | 16 | Input buffer enable |

## Verification
A wrong register value has two visible effects. For direction, data or any mask or configuration register, it shows on the matching output port one clock after the faulty write. It also shows on `bus_rdata` one clock after a read strobe. A decode fault that sends an alias to the wrong group or operation appears as an unexpected value at the next readback of both the intended and the wrongly hit register. A fault in the sampling gate or the write-priority rule appears on `pin_out` only for output bits. For input bits it is visible only by reading the data register, so those tests read the data register back straight after the sampling cycle.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

   typedef enum logic [1:0] {
      OP_PLAIN = 2'd0,
      OP_CLR   = 2'd1,
      OP_SET   = 2'd2,
      OP_TGL   = 2'd3
   } alias_op_e;

   localparam int N_GRP       = 3;            // data, mask A, mask B
   localparam int OPS_PER_GRP = 4;
   localparam int ALIAS_WORDS = N_GRP * OPS_PER_GRP;
   localparam int N_CFG       = 5;            // dir, polar, edge, both, inen
   localparam logic [1:0] SIZE_HALF = 2'b01;

   localparam logic [2:0] CFG_DIR   = 3'd0;
   localparam logic [2:0] CFG_POLAR = 3'd1;
   localparam logic [2:0] CFG_EDGE  = 3'd2;
   localparam logic [2:0] CFG_BOTH  = 3'd3;
   localparam logic [2:0] CFG_INEN  = 3'd4;

   typedef struct packed {
      logic       valid;
      logic       hit_alias;
      logic [1:0] grp;
      alias_op_e  op;
      logic       hit_cfg;
      logic [2:0] cfg;
   } dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_regbank_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output dec_t              dec
);
   localparam int WORD_W = ADDR_W - 2;

   if (ADDR_W < 7) begin : g_chk_addr
      $error("gpio_addr_dec: ADDR_W must cover offset 0x40");
   end

   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];

   always_comb begin
      dec = '0;
      if (word < WORD_W'(ALIAS_WORDS)) begin
         dec.hit_alias = 1'b1;
         dec.grp       = word[3:2];
         dec.op        = alias_op_e'(word[1:0]);
      end else if (word < WORD_W'(ALIAS_WORDS + N_CFG)) begin
         dec.hit_cfg = 1'b1;
         dec.cfg     = 3'(word - WORD_W'(ALIAS_WORDS));
      end
      dec.valid = (addr[1:0] == 2'b00) && (size == SIZE_HALF)
                  && (dec.hit_alias || dec.hit_cfg);
   end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
   import gpio_regbank_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  alias_op_e    op,
   input  logic [W-1:0] wdata,
   input  logic         smp_en,
   input  logic [W-1:0] smp_mask,
   input  logic [W-1:0] smp_val,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (wr_en) begin
         unique case (op)
            OP_PLAIN: nxt = wdata;
            OP_CLR:   nxt = q & ~wdata;
            OP_SET:   nxt = q | wdata;
            OP_TGL:   nxt = q ^ wdata;
            default:  nxt = q;
         endcase
      end else if (smp_en) begin
         nxt = (q & ~smp_mask) | (smp_val & smp_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R3
   a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_CLR) |=> (q == ($past(q) & ~$past(wdata))));
   // R4
   a_r4_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
   // R5
   a_r5_toggle_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_TGL) |=> ((q ^ $past(q)) == $past(wdata)));
   // R8: bits outside the sampling mask never move on a sampling cycle
   a_r8_sample_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && smp_en) |=> ((q & ~$past(smp_mask)) == ($past(q) & ~$past(smp_mask))));

endmodule

// File: rtl/gpio_rd_sel.sv
module gpio_rd_sel
   import gpio_regbank_pkg::*;
#(
   parameter int W = 16
) (
   input  dec_t         dec,
   input  logic [W-1:0] grp_q [N_GRP],
   input  logic [W-1:0] cfg_q [N_CFG],
   output logic [W-1:0] rd_val
);
   always_comb begin
      rd_val = '0;
      if (dec.hit_alias) begin
         for (int g = 0; g < N_GRP; g++)
            if (dec.grp == 2'(g)) rd_val = grp_q[g];
      end else if (dec.hit_cfg) begin
         for (int c = 0; c < N_CFG; c++)
            if (dec.cfg == 3'(c)) rd_val = cfg_q[c];
      end
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int NPINS  = 16,
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_wen,
   input  logic              bus_ren,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_err,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              smp_valid,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  cfg_mask_a,
   output logic [NPINS-1:0]  cfg_mask_b,
   output logic [NPINS-1:0]  cfg_polar,
   output logic [NPINS-1:0]  cfg_edge,
   output logic [NPINS-1:0]  cfg_both,
   output logic [NPINS-1:0]  cfg_inen
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_chk_pins
      $error("gpio_regbank: NPINS must lie in 1..BUS_W");
   end
   if (BUS_W != 16) begin : g_chk_bus
      $error("gpio_regbank: bus accesses are 16 bits wide");
   end

   dec_t dec;
   logic wr, rd, bad;
   logic [NPINS-1:0] grp_q [N_GRP];
   logic [NPINS-1:0] cfg_q [N_CFG];
   logic [N_GRP-1:0] grp_wr;
   logic [NPINS-1:0] rd_val;
   logic [NPINS-1:0] wval;

   gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .size(bus_size), .dec(dec));

   assign wr    = bus_wen && dec.valid;
   assign rd    = bus_ren && dec.valid;
   assign bad   = (bus_wen || bus_ren) && !dec.valid;
   assign wval  = bus_wdata[NPINS-1:0];

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      assign grp_wr[g] = wr && dec.hit_alias && (dec.grp == 2'(g));
      if (g == 0) begin : g_data
         // sampling yields to any bus write of the data group (R9)
         gpio_alias_reg #(.W(NPINS)) u_reg (
            .clk, .rst_n,
            .wr_en(grp_wr[g]), .op(dec.op), .wdata(wval),
            .smp_en(smp_valid && !grp_wr[g]),
            .smp_mask(~cfg_q[CFG_DIR] & cfg_q[CFG_INEN]),
            .smp_val(pin_in),
            .q(grp_q[g]));
      end else begin : g_mask
         gpio_alias_reg #(.W(NPINS)) u_reg (
            .clk, .rst_n,
            .wr_en(grp_wr[g]), .op(dec.op), .wdata(wval),
            .smp_en(1'b0), .smp_mask('0), .smp_val('0),
            .q(grp_q[g]));
      end
   end

   for (genvar c = 0; c < N_CFG; c++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[c] <= '0;
         else if (wr && dec.hit_cfg && dec.cfg == 3'(c))
            cfg_q[c] <= wval;
      end
   end

   gpio_rd_sel #(.W(NPINS)) u_rd (
      .dec(dec), .grp_q(grp_q), .cfg_q(cfg_q), .rd_val(rd_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err <= bad;
         if (rd)           bus_rdata <= BUS_W'(rd_val);
         else if (bus_ren) bus_rdata <= '0;
      end
   end

   assign pin_oe     = cfg_q[CFG_DIR];
   assign pin_out    = grp_q[0] & cfg_q[CFG_DIR];
   assign cfg_mask_a = grp_q[1];
   assign cfg_mask_b = grp_q[2];
   assign cfg_polar  = cfg_q[CFG_POLAR];
   assign cfg_edge   = cfg_q[CFG_EDGE];
   assign cfg_both   = cfg_q[CFG_BOTH];
   assign cfg_inen   = cfg_q[CFG_INEN];

   // R10
   a_r10_err_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> bus_err);
   // R10
   a_r10_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !wr) |=> ($stable(pin_oe) && $stable(cfg_mask_a) && $stable(cfg_mask_b)
                        && $stable(cfg_polar) && $stable(cfg_edge)
                        && $stable(cfg_both) && $stable(cfg_inen)));
   // R11
   a_r11_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && !dec.valid) |=> (bus_rdata == '0));
   // R9
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_wr[0] && dec.op == OP_PLAIN && smp_valid) |=> (grp_q[0] == $past(wval)));
   // R7
   a_r7_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

endmodule

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'b01;
   logic        bus_wen = 1'b0, bus_ren = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic [15:0] pin_in = '0;
   logic        smp_valid = 1'b0;
   logic [15:0] pin_out, pin_oe, cfg_mask_a, cfg_mask_b;
   logic [15:0] cfg_polar, cfg_edge, cfg_both, cfg_inen;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_regbank dut (
      .clk, .rst_n, .bus_addr, .bus_size, .bus_wen, .bus_ren, .bus_wdata,
      .bus_rdata, .bus_err, .pin_in, .smp_valid, .pin_out, .pin_oe,
      .cfg_mask_a, .cfg_mask_b, .cfg_polar, .cfg_edge, .cfg_both, .cfg_inen);

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] d, logic [1:0] sz = 2'b01);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_size = sz; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; bus_size = 2'b01;
   endtask

   task automatic rd(logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'b01);
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_ren = 1'b1;
      @(negedge clk);
      bus_ren = 1'b0; bus_size = 2'b01;
      d = bus_rdata;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [15:0] exp);
      logic [15:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 17; i++) rd_chk("R1 reset read", 8'(i * 4), 16'h0000);
      check("R1 pin_oe", pin_oe, 16'h0000);
      check("R1 pin_out", pin_out, 16'h0000);
      check("R1 cfg", cfg_mask_a | cfg_mask_b | cfg_polar | cfg_edge | cfg_both | cfg_inen, 16'h0000);
   endtask

   task automatic t_plain();
      logic [7:0]  adr [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40};
      for (int i = 0; i < 8; i++) wr(adr[i], 16'h1111 * 16'(i + 1));
      for (int i = 0; i < 8; i++) rd_chk("R2 plain readback", adr[i], 16'h1111 * 16'(i + 1));
      check("R2 mask A port", cfg_mask_a, 16'h2222);
      check("R2 mask B port", cfg_mask_b, 16'h3333);
      check("R2 inen port", cfg_inen, 16'h8888);
      wr(8'h30, 16'h0000);
      wr(8'h40, 16'h0000);
   endtask

   task automatic t_alias();
      for (int g = 0; g < 3; g++) begin
         logic [7:0] b = 8'(g * 16);
         wr(b, 16'hF0F0);
         wr(b + 8'h04, 16'h3030);
         rd_chk("R3 clear alias", b, 16'hC0C0);
         rd_chk("R6 read clear alias", b + 8'h04, 16'hC0C0);
         wr(b + 8'h08, 16'h000F);
         rd_chk("R4 set alias", b, 16'hC0CF);
         rd_chk("R6 read set alias", b + 8'h08, 16'hC0CF);
         wr(b + 8'h0C, 16'hFF00);
         rd_chk("R5 toggle alias", b, 16'h3FCF);
         rd_chk("R6 read toggle alias", b + 8'h0C, 16'h3FCF);
      end
      check("R5 mask B port", cfg_mask_b, 16'h3FCF);
   endtask

   task automatic t_pins();
      wr(8'h00, 16'h1234);
      wr(8'h30, 16'hFF00);
      check("R7 pin_oe", pin_oe, 16'hFF00);
      check("R7 pin_out", pin_out, 16'h1200);
      wr(8'h04, 16'h1000);
      check("R7 pin_out after clear", pin_out, 16'h0200);
   endtask

   task automatic t_sample();
      wr(8'h00, 16'h1234);
      wr(8'h30, 16'h00F0);
      wr(8'h40, 16'h0F0F);
      @(negedge clk);
      pin_in = 16'hFFFF; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      rd_chk("R8 sampled data", 8'h00, 16'h1F3F);
      check("R8 output pins unaffected", pin_out, 16'h0030);
   endtask

   task automatic t_priority();
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 16'hA5A5; bus_wen = 1'b1;
      pin_in = 16'h0000; smp_valid = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; smp_valid = 1'b0;
      rd_chk("R9 plain write wins", 8'h00, 16'hA5A5);
      @(negedge clk);
      bus_addr = 8'h08; bus_wdata = 16'h0040; bus_wen = 1'b1;
      pin_in = 16'h0000; smp_valid = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; smp_valid = 1'b0;
      rd_chk("R9 set alias wins", 8'h00, 16'hA5E5);
   endtask

   task automatic t_error();
      logic [15:0] v;
      wr(8'h34, 16'h00AA);
      @(negedge clk);
      bus_addr = 8'h34; bus_wdata = 16'h5555; bus_size = 2'b00; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; bus_size = 2'b01;
      check("R10 err after byte write", 16'(bus_err), 16'h0001);
      @(negedge clk);
      check("R10 err one cycle", 16'(bus_err), 16'h0000);
      check("R10 polar unchanged", cfg_polar, 16'h00AA);
      wr(8'h36, 16'hFFFF);
      check("R10 misaligned no change", cfg_polar, 16'h00AA);
      wr(8'h44, 16'hFFFF);
      rd_chk("R10 unmapped write no change", 8'h34, 16'h00AA);
      wr(8'h10, 16'hFFFF, 2'b10);
      check("R10 word write no change", cfg_mask_a, 16'h3FCF);
      rd(8'h50, v);
      check("R11 unmapped read zero", v, 16'h0000);
      check("R10 err on unmapped read", 16'(bus_err), 16'h0001);
      rd(8'h34, v, 2'b00);
      check("R11 byte read zero", v, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain();
      t_alias();
      t_pins();
      t_sample();
      t_priority();
      t_error();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule